// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

A supervisory timer that software must service periodically. A binary count chain advances once every second cycle of a qualified system clock. A 2-bit period field picks one of four power-of-two overflow points. Software keeps the system alive by writing one exact clear code to a command address, which restarts the count chain from zero. If the code does not arrive in time, the count overflows.

A mode bit selects what an overflow does. In interrupt mode it raises a one-cycle interrupt request, and the count wraps and keeps running. In reset mode it drives a fixed-length internal reset pulse. During that pulse the count is held and the mode settings return to their defaults. An enable bit stops the count and holds it at zero.

Registers are written through a small write port with a 1-bit address. Address 0 is the mode register: bit 0 is enable, bit 1 is reset mode, and bits 3:2 are the period. Address 1 is the command register.

Top module: `wdog_timer`

## Requirements
- R1: After rst_ni is released, irq_o and wdt_rst_o are low and the mode register holds enable=1, reset mode=0, period=00. Counting therefore runs on the shortest tap in interrupt mode.
- R2: The count advances once per two cycles in which cnt_en_i is high. With cnt_en_i held high, the first overflow after a restart is seen as irq_o high in the cycle after clock edge number 2^(tap+1), counting the restart edge as edge 0.
- R3: Mode bits 3:2 select the tap: 00, 01, 10 and 11 give TAP0, TAP0+TAP_STEP, TAP0+2*TAP_STEP and TAP0+3*TAP_STEP. With the defaults these are 15, 17, 19 and 21.
- R4: In interrupt mode (mode bit 1 = 0) each overflow gives an irq_o pulse exactly one cycle long. The count wraps to zero, so the next pulse follows one full period later.
- R5: In reset mode (mode bit 1 = 1) an overflow raises wdt_rst_o for exactly RST_LEN cycles (24 by default) and raises no irq_o.
- R6: While wdt_rst_o is high the count is held at zero and the mode register is forced to its defaults. Counting then resumes from zero on the edge after the pulse ends, in interrupt mode on period 00.
- R7: Writing 0x4E to address 1 restarts the count chain, both counter and divide-by-two phase, from zero.
- R8: Writing any value other than 0x4E to address 1 leaves the count untouched, so the pending overflow keeps its original time.
- R9: While the enable bit (mode bit 0) is 0 the count is held at zero and no overflow occurs. Setting the bit to 1 starts the count from zero as a clear would.
- R10: Cycles with cnt_en_i low pause the count chain without losing state, delaying the overflow by exactly that number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Clock enable qualifying the count chain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = mode register, 1 = command register |
| wr_data_i | input | DATA_W | Write data |
| irq_o | output | 1 | One-cycle overflow interrupt request |
| wdt_rst_o | output | 1 | Timed internal reset pulse |

## Verification
The assertions assume that write strobes are single-cycle and that the write data is stable only in the strobe cycle. They also assume that cnt_en_i is a plain level with no relation to the writes. The stimulus drives every input at the falling edge and keeps each write to one cycle. It turns the count off before changing mode, so that a free-running periodic interrupt never overlaps the next scenario. The bench uses a reduced tap set (CNT_W=10, TAP0=3), which keeps every period to at most 1024 cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic [1:0] period;
    logic       rst_mode;
    logic       enable;
  } wdog_mode_t;

  localparam wdog_mode_t MODE_DEF = '{period: 2'b00, rst_mode: 1'b0, enable: 1'b1};

  typedef enum logic {
    ADDR_MODE = 1'b0,
    ADDR_CMD  = 1'b1
  } wdog_addr_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  CLR_CODE = 8'h4E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hold_i,
  output wdog_mode_t        mode_o,
  output logic              clear_o
);
  wdog_mode_t mode_q;
  logic       wr_mode, wr_cmd;

  assign wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign wr_cmd  = wr_en_i && (wr_addr_i == ADDR_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_DEF;
    else if (hold_i)  mode_q <= MODE_DEF;
    else if (wr_mode) mode_q <= wdog_mode_t'(wr_data_i[3:0]);
  end

  // only the exact code restarts the chain
  assign clear_o = wr_cmd && !hold_i && (wr_data_i == DATA_W'(CLR_CODE));
  assign mode_o  = mode_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic cnt_en_i,
  output logic tick_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tog_q <= 1'b0;
    else if (restart_i) tog_q <= 1'b0;
    else if (cnt_en_i)  tog_q <= ~tog_q;
  end

  assign tick_o = cnt_en_i && tog_q && !restart_i;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W    = 22,
  parameter int TAP0     = 15,
  parameter int TAP_STEP = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [1:0] period_i,
  output logic       ovf_o
);
  localparam int SEL_N = 4;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_a [SEL_N];
  logic [CNT_W-1:0] lim;

  for (genvar g = 0; g < SEL_N; g++) begin : g_tap
    localparam int TAP = TAP0 + TAP_STEP * g;
    assign lim_a[g] = {CNT_W{1'b1}} >> (CNT_W - TAP);
  end

  assign lim   = lim_a[period_i];
  // >= so a shortened period cannot run on to a full wrap
  assign ovf_o = tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (ovf_o)     cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int RST_LEN = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int RW = $clog2(RST_LEN + 1);

  logic [RW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= RW'(RST_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int         CNT_W    = 22,
  parameter int         TAP0     = 15,
  parameter int         TAP_STEP = 2,
  parameter int         RST_LEN  = 24,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] CLR_CODE = 8'h4E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  wdog_mode_t mode_q;
  logic clear, restart, tick, ovf, rst_act, irq_q;

  wdog_regs #(.DATA_W(DATA_W), .CLR_CODE(CLR_CODE)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .hold_i(rst_act), .mode_o(mode_q), .clear_o(clear)
  );

  assign restart = clear || !mode_q.enable || rst_act;

  wdog_prescale u_pre (
    .clk_i, .rst_ni, .restart_i(restart), .cnt_en_i, .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .TAP0(TAP0), .TAP_STEP(TAP_STEP)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i(tick),
    .period_i(mode_q.period), .ovf_o(ovf)
  );

  wdog_rst_gen #(.RST_LEN(RST_LEN)) u_rst (
    .clk_i, .rst_ni, .fire_i(ovf && mode_q.rst_mode), .active_o(rst_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ovf && !mode_q.rst_mode;
  end

  assign irq_o     = irq_q;
  assign wdt_rst_o = rst_act;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int         CNT_W    = 22,
  parameter int         RST_LEN  = 24,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] CLR_CODE = 8'h4E
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              irq_o,
  input logic              wdt_rst_o,
  input logic              en_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic [7:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt_q <= '0;
    else if (wdt_rst_o) hi_cnt_q <= hi_cnt_q + 1'b1;
    else                hi_cnt_q <= '0;
  end

  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_no_irq_in_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !irq_o);

  a_r5_rst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (hi_cnt_q == 8'(RST_LEN)));

  a_r6_rst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> (cnt_q == '0));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i && (wr_data_i == DATA_W'(CLR_CODE))) |=> (cnt_q == '0));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> ((cnt_q == '0) && !irq_o));
endmodule

bind wdog_timer wdog_timer_chk #(
  .CNT_W(CNT_W), .RST_LEN(RST_LEN), .DATA_W(DATA_W), .CLR_CODE(CLR_CODE)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .irq_o, .wdt_rst_o,
  .en_q(mode_q.enable), .cnt_q(u_cnt.cnt_q)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CNT_W = 10, TAP0 = 3, TAP_STEP = 2, RST_LEN = 24;

  typedef enum int {EV_IRQ, EV_RST_ON, EV_RST_OFF} ev_e;
  typedef struct {
    ev_e   kind;
    int    cyc;
    string req;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0, cnt_en = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic irq, wrst;
  int cyc = 0, total = 0, bad = 0, seen = 0;
  bit done = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer #(.CNT_W(CNT_W), .TAP0(TAP0), .TAP_STEP(TAP_STEP), .RST_LEN(RST_LEN)) u_wdog_timer (
    .clk_i(clk), .rst_ni, .cnt_en_i(cnt_en), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_o(irq), .wdt_rst_o(wrst)
  );

  function automatic int per(input int sel);
    return 2 ** (TAP0 + TAP_STEP * sel + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic push(input ev_e k, input int c, input string req);
    item_t it;
    it.kind = k; it.cyc = c; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, output int c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: turn output activity into events and score them
  logic prev_rst = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      ev_e k;
      bit hit;
      hit = 1'b0;
      k = EV_IRQ;
      if (irq) begin k = EV_IRQ; hit = 1'b1; end
      else if (wrst && !prev_rst) begin k = EV_RST_ON; hit = 1'b1; end
      else if (!wrst && prev_rst) begin k = EV_RST_OFF; hit = 1'b1; end
      prev_rst <= wrst;
      if (hit) begin
        seen++;
        if (exp_q.size() == 0) check(1'b0, "unexpected event", cyc, int'(k));
        else begin
          item_t it;
          it = exp_q.pop_front();
          check(it.kind == k, it.req, int'(k), int'(it.kind));
          check(it.cyc == cyc, it.req, cyc, it.cyc);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, c1, tmp, s0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq reset", int'(irq), 0);
    check(wrst == 1'b0, "R1 rst reset", int'(wrst), 0);

    // R1/R2: defaults -> period 00, interrupt mode
    wr(1'b1, 8'h4E, c0);
    push(EV_IRQ, c0 + per(0), "R1 default period");
    push(EV_IRQ, c0 + 2 * per(0), "R4 wrap");
    push(EV_IRQ, c0 + 3 * per(0), "R4 wrap");
    wait_until(c0 + 3 * per(0));
    wr(1'b0, 8'h00, tmp);

    // R3: each period tap
    for (int s = 1; s < 4; s++) begin
      wr(1'b0, 8'((s << 2) | 1), c0);
      push(EV_IRQ, c0 + per(s), "R3 tap select");
      wait_until(c0 + per(s));
      wr(1'b0, 8'h00, tmp);
    end

    // R8: wrong codes do not restart
    wr(1'b0, 8'h05, c0);
    push(EV_IRQ, c0 + per(1), "R8 wrong code ignored");
    wait_until(c0 + 30);
    wr(1'b1, 8'h4F, tmp);
    wr(1'b1, 8'h00, tmp);
    wait_until(c0 + per(1));
    wr(1'b0, 8'h00, tmp);

    // R7: exact code restarts
    wr(1'b0, 8'h05, c0);
    wait_until(c0 + 40);
    wr(1'b1, 8'h4E, c1);
    push(EV_IRQ, c1 + per(1), "R7 clear restart");
    wait_until(c1 + per(1));
    wr(1'b0, 8'h00, tmp);

    // R10: cnt_en low pauses the chain
    wr(1'b0, 8'h01, c0);
    push(EV_IRQ, c0 + per(0) + 10, "R10 pause");
    wait_until(c0 + 5);
    cnt_en = 1'b0;
    repeat (10) @(negedge clk);
    cnt_en = 1'b1;
    wait_until(c0 + per(0) + 10);
    wr(1'b0, 8'h00, tmp);

    // R5/R6: reset mode on period 01, then defaults afterwards
    wr(1'b0, 8'h07, c0);
    push(EV_RST_ON, c0 + per(1), "R5 rst start");
    push(EV_RST_OFF, c0 + per(1) + RST_LEN, "R5 rst length");
    push(EV_IRQ, c0 + per(1) + RST_LEN + per(0), "R6 defaults after pulse");
    wait_until(c0 + per(1) + RST_LEN + per(0));
    wr(1'b0, 8'h00, tmp);

    // R9: disabled -> nothing happens, then enable restarts from zero
    s0 = seen;
    repeat (3000) @(negedge clk);
    check(seen == s0, "R9 disabled silent", seen - s0, 0);
    wr(1'b0, 8'h01, c0);
    push(EV_IRQ, c0 + per(0), "R9 enable restart");
    wait_until(c0 + per(0));
    wr(1'b0, 8'h00, tmp);

    repeat (20) @(negedge clk);
    while (exp_q.size() != 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(1'b0, it.req, -1, it.cyc);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule